// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Output Aliases

This block is one memory-mapped 32-bit general-purpose I/O port. Software drives the output latch directly, or changes selected bits in one access through three write-only alias registers: one sets bits, one clears bits and one inverts bits. A direction register drives the per-pin output enables. The pin levels, which may change at any time, pass through a two-flop synchronizer before software can read them.

The slave side is a simple valid/ready bus. Legal accesses complete in the cycle they are presented. An access to an address outside the map, or to an address that is not word-aligned, takes one wait state and then reports a bus error. A two-state controller (`BUS_IDLE`, `BUS_ERR_WAIT`) sequences that response. The transition `T_ILLEGAL` (IDLE to ERR_WAIT) is taken on a valid request to a bad address. The transition `T_RESPOND` (ERR_WAIT to IDLE) is always taken in the following cycle. In every other case the controller stays in IDLE.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset the output latch and the direction register are 0, so `pin_out` and `pin_oe` are all zero and both registers read back 0.
- R2: The output latch at byte offset 0x00 is read/write. A write reaches `pin_out` on the clock edge that accepts it, and a read returns the latch value.
- R3: A write to the set alias at offset 0x04 forces to 1 every output bit written as 1. Bits written as 0 keep their value.
- R4: A write to the clear alias at offset 0x08 forces to 0 every output bit written as 1. Bits written as 0 keep their value.
- R5: A write to the toggle alias at offset 0x0C inverts every output bit written as 1. Bits written as 0 keep their value.
- R6: A read of any of the three aliases returns 0 and completes without error.
- R7: The input register at offset 0x10 returns `pin_in` through two flops. A pin change made before clock edge k is visible to a read presented after edge k+1 and not to a read presented between edges k and k+1. Writes to 0x10 change nothing and complete without error.
- R8: The direction register at offset 0x14 is read/write and drives `pin_oe` bit for bit (1 = drive).
- R9: A legal access (word-aligned, offset 0x00 to 0x14) has `bus_ready` high and `bus_error` low in the cycle it is presented. Reads and writes of legal addresses are both zero-wait.
- R10: An access to any other address has `bus_ready` low in its first cycle. In the second cycle it has `bus_ready` and `bus_error` high and `bus_rdata` 0. Such an access changes no register.
- R11: Writes presented in back-to-back cycles that touch the same bits each take effect in order, one per clock, with no lost update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address within the port |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes this cycle |
| bus_error | output | 1 | Completing access is a bus error |
| pin_in | input | DW | Asynchronous pin levels |
| pin_out | output | DW | Output latch driving the pins |
| pin_oe | output | DW | Per-pin output enable |

## Verification
A legal read returns its data and `bus_ready` in the cycle it is presented. A write shows on `pin_out`/`pin_oe` right after the edge that accepts it. An errored access completes exactly one cycle late. A pin change becomes readable only after the second edge that follows it. The driver presents requests on the falling edge. Both driver and monitor sample a quarter period later, so each result is compared in the cycle it is due. The monitor counts the wait cycles of every access against the expected count (0 or 1). For the synchronizer, the bench reads one cycle too early and expects the old value, then reads one cycle later and expects the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Byte offsets of the register map
    localparam int unsigned OFS_OUT  = 'h00;
    localparam int unsigned OFS_SET  = 'h04;
    localparam int unsigned OFS_CLR  = 'h08;
    localparam int unsigned OFS_TGL  = 'h0C;
    localparam int unsigned OFS_IN   = 'h10;
    localparam int unsigned OFS_DIR  = 'h14;
    localparam int unsigned OFS_LAST = OFS_DIR;

    typedef enum logic [2:0] {
        SEL_OUT,
        SEL_SET,
        SEL_CLR,
        SEL_TGL,
        SEL_IN,
        SEL_DIR,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_ERR_WAIT
    } bus_state_e;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output logic          legal
);
    localparam int IW = AW - 2;
    localparam logic [IW-1:0] IDX_OUT = IW'(OFS_OUT >> 2);
    localparam logic [IW-1:0] IDX_SET = IW'(OFS_SET >> 2);
    localparam logic [IW-1:0] IDX_CLR = IW'(OFS_CLR >> 2);
    localparam logic [IW-1:0] IDX_TGL = IW'(OFS_TGL >> 2);
    localparam logic [IW-1:0] IDX_IN  = IW'(OFS_IN  >> 2);
    localparam logic [IW-1:0] IDX_DIR = IW'(OFS_DIR >> 2);

    logic [IW-1:0] widx;
    logic          aligned;

    assign widx    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            case (widx)
                IDX_OUT: sel = SEL_OUT;
                IDX_SET: sel = SEL_SET;
                IDX_CLR: sel = SEL_CLR;
                IDX_TGL: sel = SEL_TGL;
                IDX_IN:  sel = SEL_IN;
                IDX_DIR: sel = SEL_DIR;
                default: sel = SEL_NONE;
            endcase
        end
    end

    assign legal = (sel != SEL_NONE);

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_legal,
    output logic rsp_ready,
    output logic rsp_error,
    output logic acc_go
);
    bus_state_e state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:     if (req_valid && !req_legal) state_d = BUS_ERR_WAIT; // T_ILLEGAL
            BUS_ERR_WAIT: state_d = BUS_IDLE;                                 // T_RESPOND
            default:      state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rsp_ready = 1'b1;
        rsp_error = 1'b0;
        acc_go    = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                rsp_ready = !(req_valid && !req_legal);
                acc_go    = req_valid && req_legal;
            end
            BUS_ERR_WAIT: begin
                rsp_ready = 1'b1;
                rsp_error = 1'b1;
            end
            default: begin
                rsp_ready = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pins_sync,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] dir_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_OUT: out_q <= wdata;
                SEL_SET: out_q <= out_q | wdata;
                SEL_CLR: out_q <= out_q & ~wdata;
                SEL_TGL: out_q <= out_q ^ wdata;
                SEL_DIR: dir_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_OUT: rdata = out_q;
                SEL_IN:  rdata = pins_sync;
                SEL_DIR: rdata = dir_q;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ready,
    output logic          bus_error,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe
);
    reg_sel_e      sel;
    logic          legal;
    logic          acc_go;
    logic [DW-1:0] pins_sync;

    gpio_decode #(.AW(AW)) i_decode (
        .addr  (bus_addr),
        .sel   (sel),
        .legal (legal)
    );

    gpio_bus_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .req_legal (legal),
        .rsp_ready (bus_ready),
        .rsp_error (bus_error),
        .acc_go    (acc_go)
    );

    gpio_sync #(.W(DW), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_regfile #(.DW(DW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_go && bus_write),
        .rd_en     (acc_go && !bus_write),
        .sel       (sel),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .out_q     (pin_out),
        .dir_q     (pin_oe)
    );

endmodule

// File: rtl/gpio_alias_port_chk.sv
module gpio_alias_port_chk #(
    parameter int DW = 32,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_ready,
    input logic          bus_error,
    input logic [DW-1:0] pin_out,
    input logic [DW-1:0] pin_oe
);
    logic in_map, wr_done, out_grp;
    assign in_map  = (bus_addr[1:0] == 2'b00) && (bus_addr <= AW'('h14));
    assign wr_done = bus_valid && bus_write && bus_ready && !bus_error;
    assign out_grp = (bus_addr[1:0] == 2'b00) && (bus_addr <= AW'('h0C));

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (pin_out == '0 && pin_oe == '0)); // R1
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && bus_addr == AW'('h04)) |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R3
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && bus_addr == AW'('h08)) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R4
    AST_TGL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && bus_addr == AW'('h0C)) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata))); // R5
    AST_ALIAS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_ready &&
         (bus_addr == AW'('h04) || bus_addr == AW'('h08) || bus_addr == AW'('h0C))) |-> bus_rdata == '0); // R6
    AST_IN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && bus_addr == AW'('h10)) |=> ($stable(pin_out) && $stable(pin_oe))); // R7
    AST_DIR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && bus_addr == AW'('h14)) |=> pin_oe == $past(bus_wdata)); // R8
    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && in_map) |-> (bus_ready && !bus_error)); // R9
    AST_ERR_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !in_map && !bus_error) |-> !bus_ready); // R10
    AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !in_map && !bus_error) |=> (bus_ready && bus_error)); // R10
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |=> !bus_error); // R10
    AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |-> bus_rdata == '0); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && out_grp) |=> $stable(pin_out)); // R11

endmodule

bind gpio_alias_port gpio_alias_port_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .bus_error (bus_error),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_alias_port.sv
module test_gpio_alias_port;
    localparam int CLK_PERIOD = 10;
    localparam int Q  = CLK_PERIOD / 4;
    localparam int DW = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          bus_error;
    logic [DW-1:0] pin_in = '0;
    logic [DW-1:0] pin_out;
    logic [DW-1:0] pin_oe;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [DW-1:0] out_m = '0;
    logic [DW-1:0] dir_m = '0;

    typedef struct {
        logic [DW-1:0] rd;
        bit            err;
        int            waits;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_alias_port #(.DW(DW), .AW(AW)) i_gpio_alias_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_error (bus_error),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // driver: pushes the expected response and presents the request
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] erd, input bit eerr, input int ew, input string tag);
        exp_t it;
        bit   r;
        it.rd = erd; it.err = eerr; it.waits = ew; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        do begin
            #(Q);
            r = bus_ready;
            @(posedge clk);
            if (!r) @(negedge clk);
        end while (!r);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic single(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] erd, input bit eerr, input int ew, input string tag);
        access(wr, a, d, erd, eerr, ew, tag);
        idle();
    endtask

    // monitor: pops and compares at each completing cycle
    initial begin
        int waits = 0;
        forever begin
            @(negedge clk);
            #(Q);
            if (rst_n && bus_valid) begin
                if (!bus_ready) waits++;
                else begin
                    exp_t it;
                    n_vec++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL unexpected completion: actual rdata %h expected none", bus_rdata);
                    end else begin
                        it = exp_q.pop_front();
                        if (bus_rdata !== it.rd || bus_error !== it.err || waits != it.waits) begin
                            n_fail++;
                            $display("FAIL %s: actual rdata %h err %0b waits %0d expected rdata %h err %0b waits %0d",
                                     it.tag, bus_rdata, bus_error, waits, it.rd, it.err, it.waits);
                        end
                    end
                    waits = 0;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        single(0, 12'h000, '0, '0, 0, 0, "R1 OUT read");
        single(0, 12'h014, '0, '0, 0, 0, "R1 DIR read");

        // R2 output latch, R9 zero wait
        out_m = 32'hA5A5_0F0F;
        access(1, 12'h000, out_m, '0, 0, 0, "R9 OUT write");
        #1 check("R2 pin_out after write edge", pin_out, out_m);
        idle();
        single(0, 12'h000, '0, out_m, 0, 0, "R2 OUT read");

        // R3 set alias
        single(1, 12'h004, 32'h0000_F0F0, '0, 0, 0, "R3 SET write");
        out_m = out_m | 32'h0000_F0F0;
        check("R3 pin_out", pin_out, out_m);
        // R4 clear alias
        single(1, 12'h008, 32'hFF00_0001, '0, 0, 0, "R4 CLR write");
        out_m = out_m & ~32'hFF00_0001;
        check("R4 pin_out", pin_out, out_m);
        // R5 toggle alias
        single(1, 12'h00C, 32'h8000_00FF, '0, 0, 0, "R5 TGL write");
        out_m = out_m ^ 32'h8000_00FF;
        check("R5 pin_out", pin_out, out_m);
        single(0, 12'h000, '0, out_m, 0, 0, "R5 OUT read");

        // R6 aliases read zero
        single(0, 12'h004, '0, '0, 0, 0, "R6 SET read");
        single(0, 12'h008, '0, '0, 0, 0, "R6 CLR read");
        single(0, 12'h00C, '0, '0, 0, 0, "R6 TGL read");

        // R8 direction
        dir_m = 32'hFFFF_0000;
        single(1, 12'h014, dir_m, '0, 0, 0, "R8 DIR write");
        check("R8 pin_oe", pin_oe, dir_m);
        single(0, 12'h014, '0, dir_m, 0, 0, "R8 DIR read");

        // R7 synchronizer latency: old value one edge after change, new after two
        @(negedge clk);
        pin_in = 32'h1234_5678;
        access(0, 12'h010, '0, 32'h0000_0000, 0, 0, "R7 IN read too early");
        access(0, 12'h010, '0, 32'h1234_5678, 0, 0, "R7 IN read after two edges");
        idle();
        // R7 write to IN ignored
        single(1, 12'h010, 32'hFFFF_FFFF, '0, 0, 0, "R7 IN write no error");
        check("R7 pin_out after IN write", pin_out, out_m);
        check("R7 pin_oe after IN write", pin_oe, dir_m);
        single(0, 12'h010, '0, 32'h1234_5678, 0, 0, "R7 IN read after write");

        // R10 illegal addresses
        single(1, 12'h018, 32'hDEAD_BEEF, '0, 1, 1, "R10 write past map");
        single(1, 12'h006, 32'hFFFF_FFFF, '0, 1, 1, "R10 unaligned write");
        single(0, 12'hFFC, '0, '0, 1, 1, "R10 read high address");
        access(0, 12'h002, '0, '0, 1, 1, "R10 unaligned read back-to-back 1");
        access(1, 12'h015, 32'h0, '0, 1, 1, "R10 unaligned DIR back-to-back 2");
        idle();
        check("R10 pin_out unchanged", pin_out, out_m);
        check("R10 pin_oe unchanged", pin_oe, dir_m);
        single(0, 12'h000, '0, out_m, 0, 0, "R10 OUT read unchanged");

        // R11 back-to-back writes on the same bits
        access(1, 12'h000, 32'h0000_0000, '0, 0, 0, "R11 OUT clear");
        access(1, 12'h004, 32'h0000_0001, '0, 0, 0, "R11 SET bit0");
        access(1, 12'h00C, 32'h0000_0003, '0, 0, 0, "R11 TGL bits1:0");
        access(1, 12'h00C, 32'h0000_0002, '0, 0, 0, "R11 TGL bit1");
        access(1, 12'h004, 32'h0000_0010, '0, 0, 0, "R11 SET bit4");
        access(1, 12'h008, 32'h0000_0010, '0, 0, 0, "R11 CLR bit4");
        access(1, 12'h00C, 32'h0000_0100, '0, 0, 0, "R11 TGL bit8");
        out_m = 32'h0000_0100;
        access(0, 12'h000, '0, out_m, 0, 0, "R11 OUT read after burst");
        idle();
        check("R11 pin_out", pin_out, out_m);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL queue: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule